// File: doc/BRIEF.md
# Per-Bit Edge/Level Trigger Matcher

This block watches the sample stream of a logic analyzer and reports when it meets a trigger condition. Three per-bit configuration words define that condition. A select word chooses which bits take part. A polarity word gives the wanted level or the wanted edge direction. A mode word picks, for each bit, whether it is matched as a level or as a transition. Level bits and transition bits may be mixed in one condition.

A transition is judged between two successive accepted samples, not between successive clock cycles. A history register captures the bus only on cycles where the sample strobe is high. Triggering therefore stays correct when samples arrive on only some clock cycles. A pulse on the arm input starts a search. The first sample that meets every selected condition produces a single registered pulse on the hit output. The block then stops searching until it is armed again.

Top module: `etrig_matcher`

## Requirements
- R1: After reset the block is disarmed. `hit` is low, and no sample produces a hit until `arm` has been pulsed.
- R2: A bit whose `cfg_mask` bit is 0 has no effect on matching. With `cfg_mask` all zero, the first valid sample after arming produces a hit.
- R3: A selected bit with `cfg_edge` = 0 is a level condition. It is met when the current sample bit equals the `cfg_value` bit (1 = high, 0 = low).
- R4: A selected bit with `cfg_edge` = 1 is a transition condition. `cfg_value` = 1 requires the bit to go from 0 in the previous accepted sample to 1 in the current one. `cfg_value` = 0 requires it to go from 1 to 0.
- R5: A hit requires every selected bit, level bits and transition bits alike, to meet its condition on the same sample.
- R6: The previous sample is the last one presented with `smp_vld` = 1. Bus values on cycles with `smp_vld` = 0 are never evaluated and never enter the history.
- R7: The first valid sample after arming cannot satisfy a transition bit, because no history exists yet for the current search.
- R8: `hit` is registered. It rises in the clock cycle after the matching sample is presented and stays high for exactly one cycle.
- R9: After a hit the block is disarmed. No further hit occurs until `arm` is pulsed again.
- R10: A cycle with `arm` high starts a new search. The sample presented in that cycle is not evaluated, and earlier samples do not serve as history for the new search.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arm | input | 1 | Start a new search; clears the history |
| smp_vld | input | 1 | Sample strobe; high when `smp_data` carries a sample |
| smp_data | input | WIDTH | Sample bus |
| cfg_mask | input | WIDTH | Per-bit select: 1 = bit takes part in the condition |
| cfg_value | input | WIDTH | Per-bit level (high/low) or transition direction (rising/falling) |
| cfg_edge | input | WIDTH | Per-bit mode: 1 = transition, 0 = level |
| hit | output | 1 | One-cycle pulse when the condition is met |

## Verification
A corrupted history register shows up as a wrong hit or a missing hit on the first transition-enabled sample that follows it. The bench therefore places idle cycles carrying scrambled bus values between accepted samples. A history-valid flag that is left set across an arm lets a transition bit fire on the very first sample, one cycle after it is presented. A stuck armed flag shows as a second pulse on the next matching sample after a hit. The sweep covers every mask, polarity and mode combination of a four-bit bus against several sample pairs, so any wrong per-bit term is exposed within one search.

// File: rtl/etrig_pkg.sv
package etrig_pkg;

    // Configuration of one sample bit
    typedef struct packed {
        logic sel;      // bit takes part in the condition
        logic pol;      // level high / rising when set
        logic trans;    // transition condition instead of level
    } bit_cfg_t;

endpackage

// File: rtl/etrig_bit_cell.sv
module etrig_bit_cell
    import etrig_pkg::*;
(
    input  bit_cfg_t cfg,
    input  logic     cur,
    input  logic     prev,
    input  logic     hist_ok,
    output logic     ok
);

    logic level_met;
    logic moved;

    always_comb begin
        level_met = (cur == cfg.pol);
        moved     = hist_ok & (cur ^ prev);
        if (!cfg.sel) begin
            ok = 1'b1;
        end else if (cfg.trans) begin
            ok = level_met & moved;
        end else begin
            ok = level_met;
        end
    end

endmodule

// File: rtl/etrig_arm_ctrl.sv
module etrig_arm_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic smp_vld,
    input  logic all_ok,
    output logic hist_ok,
    output logic hit
);

    typedef struct packed {
        logic armed;
        logic hist;
        logic pulse;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  fire;

    always_comb begin
        st_d = st_q;
        fire = st_q.armed & ~arm & smp_vld & all_ok;
        st_d.pulse = fire;
        if (arm) begin
            st_d.armed = 1'b1;
            st_d.hist  = 1'b0;
        end else begin
            if (fire) begin
                st_d.armed = 1'b0;
            end
            if (smp_vld && st_q.armed) begin
                st_d.hist = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hist_ok = st_q.hist;
    assign hit     = st_q.pulse;

endmodule

// File: rtl/etrig_matcher.sv
module etrig_matcher
    import etrig_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             smp_vld,
    input  logic [WIDTH-1:0] smp_data,
    input  logic [WIDTH-1:0] cfg_mask,
    input  logic [WIDTH-1:0] cfg_value,
    input  logic [WIDTH-1:0] cfg_edge,
    output logic             hit
);

    localparam int MSB = WIDTH - 1;

    typedef struct packed {
        logic [MSB:0] prev;
    } hist_t;

    hist_t        hs_d, hs_q;
    logic [MSB:0] bit_ok;
    logic         all_ok;
    logic         hist_ok;

    // History captures only accepted samples
    always_comb begin
        hs_d = hs_q;
        if (smp_vld) begin
            hs_d.prev = smp_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q <= '0;
        end else begin
            hs_q <= hs_d;
        end
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        bit_cfg_t cfg_i;
        assign cfg_i.sel   = cfg_mask[i];
        assign cfg_i.pol   = cfg_value[i];
        assign cfg_i.trans = cfg_edge[i];

        etrig_bit_cell u_cell (
            .cfg     (cfg_i),
            .cur     (smp_data[i]),
            .prev    (hs_q.prev[i]),
            .hist_ok (hist_ok),
            .ok      (bit_ok[i])
        );
    end

    assign all_ok = &bit_ok;

    etrig_arm_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm     (arm),
        .smp_vld (smp_vld),
        .all_ok  (all_ok),
        .hist_ok (hist_ok),
        .hit     (hit)
    );

endmodule

// File: rtl/etrig_matcher_chk.sv
module etrig_matcher_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             arm,
    input logic             smp_vld,
    input logic [WIDTH-1:0] smp_data,
    input logic [WIDTH-1:0] cfg_mask,
    input logic [WIDTH-1:0] cfg_value,
    input logic [WIDTH-1:0] cfg_edge,
    input logic [WIDTH-1:0] prev_data,
    input logic             hist_ok,
    input logic             hit
);

    // Set by a hit, cleared by arm: a second hit without re-arming is an error
    logic spent_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spent_q <= 1'b0;
        end else if (arm) begin
            spent_q <= 1'b0;
        end else if (hit) begin
            spent_q <= 1'b1;
        end
    end

    AST_HIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> !hit); // R8

    AST_HIT_FROM_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ($past(smp_vld) && !$past(arm))); // R10

    AST_LEVEL_MET: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((($past(smp_data) ^ $past(cfg_value)) & $past(cfg_mask)) == '0)); // R3

    AST_EDGE_MOVED: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((($past(smp_data) ^ $past(prev_data)) & $past(cfg_mask) & $past(cfg_edge))
                 == ($past(cfg_mask) & $past(cfg_edge)))); // R4

    AST_FIRST_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !$past(hist_ok)) |-> (($past(cfg_mask) & $past(cfg_edge)) == '0)); // R7

    AST_DISARMED_AFTER_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> !spent_q); // R9

endmodule

bind etrig_matcher etrig_matcher_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .arm       (arm),
    .smp_vld   (smp_vld),
    .smp_data  (smp_data),
    .cfg_mask  (cfg_mask),
    .cfg_value (cfg_value),
    .cfg_edge  (cfg_edge),
    .prev_data (hs_q.prev),
    .hist_ok   (hist_ok),
    .hit       (hit)
);

// File: tb/etrig_matcher_tb.sv
`timescale 1ns/1ps
module etrig_matcher_tb;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         arm = 1'b0;
    logic         smp_vld = 1'b0;
    logic [W-1:0] smp_data = '0;
    logic [W-1:0] cfg_mask = '0;
    logic [W-1:0] cfg_value = '0;
    logic [W-1:0] cfg_edge = '0;
    logic         hit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    etrig_matcher #(.WIDTH(W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .smp_vld   (smp_vld),
        .smp_data  (smp_data),
        .cfg_mask  (cfg_mask),
        .cfg_value (cfg_value),
        .cfg_edge  (cfg_edge),
        .hit       (hit)
    );

    task automatic check(input logic exp, input string tag);
        checks++;
        if (hit !== exp) begin
            errors++;
            $display("FAIL %s mask=%b val=%b edge=%b data=%b hit=%b expected=%b",
                     tag, cfg_mask, cfg_value, cfg_edge, smp_data, hit, exp);
        end
    endtask

    // Drive one cycle at a negedge, check hit at the following negedge
    task automatic cyc(input logic a, input logic v, input logic [W-1:0] d,
                       input logic exp, input string tag);
        arm      = a;
        smp_vld  = v;
        smp_data = d;
        @(negedge clk);
        check(exp, tag);
    endtask

    // First sample after arming: no history, so only level terms can hold
    function automatic logic exp_first(input logic [W-1:0] m, v, e, c);
        logic r = 1'b1;
        for (int i = 0; i < W; i++)
            if (m[i] && (e[i] || c[i] != v[i])) r = 1'b0;
        return r;
    endfunction

    function automatic logic exp_next(input logic [W-1:0] m, v, e, p, c);
        logic r = 1'b1;
        for (int i = 0; i < W; i++) begin
            if (m[i]) begin
                if (c[i] != v[i]) r = 1'b0;
                if (e[i] && p[i] == c[i]) r = 1'b0;
            end
        end
        return r;
    endfunction

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        check(1'b0, "R1 reset");
        @(negedge clk);
        rst_n = 1'b1;

        // R1: never armed, empty mask, samples do not hit
        cyc(0, 1, 4'h3, 0, "R1 unarmed");
        cyc(0, 1, 4'hC, 0, "R1 unarmed");

        // R2: empty mask matches on first valid sample; R8 pulse one cycle wide
        cyc(1, 0, 4'h0, 0, "R10 arm");
        cyc(0, 0, 4'h5, 0, "R6 idle");
        cyc(0, 1, 4'h9, 1, "R2 empty mask");
        cyc(0, 0, 4'h9, 0, "R8 pulse width");
        // R9: disarmed after hit
        cyc(0, 1, 4'h9, 0, "R9 disarmed");
        cyc(0, 1, 4'h6, 0, "R9 disarmed");

        // R10: sample in the arm cycle is not evaluated and gives no history
        cfg_mask = 4'b0001; cfg_value = 4'b0001; cfg_edge = 4'b0001;
        cyc(0, 1, 4'h0, 0, "R10 pre");
        cyc(1, 1, 4'h0, 0, "R10 arm sample");
        cyc(0, 1, 4'h1, 0, "R7 first edge");
        cyc(0, 1, 4'h0, 0, "R4 falling vs rising");
        cyc(0, 0, 4'h0, 0, "R6 idle");
        cyc(0, 0, 4'h1, 0, "R6 idle ignored");
        cyc(0, 1, 4'h1, 1, "R4 rising over idle gap");
        // R10: arm in the cycle a matching sample arrives suppresses it
        cfg_mask = 4'b0000;
        cyc(1, 1, 4'h1, 0, "R10 arm suppresses");
        cyc(0, 1, 4'h2, 1, "R2 after re-arm");

        // Sweep every mask/value/mode combination with several sample pairs
        for (int cfg = 0; cfg < 4096; cfg++) begin
            for (int j = 0; j < 4; j++) begin
                logic [W-1:0] m, v, e, p, c;
                logic x0, x1;
                int idle;
                m = cfg[3:0]; v = cfg[7:4]; e = cfg[11:8];
                case (j)
                    0: begin c = v;                       p = ~v;          end
                    1: begin c = v;                       p = v;           end
                    2: begin c = v ^ (4'b1 << (cfg % 4)); p = ~c;          end
                    default: begin c = v ^ cfg[3:0] ^ 4'h5; p = c ^ e;     end
                endcase
                idle = (cfg + j) % 3;
                cfg_mask = m; cfg_value = v; cfg_edge = e;
                x0 = exp_first(m, v, e, p);
                x1 = x0 ? 1'b0 : exp_next(m, v, e, p, c);
                cyc(1, 0, ~p, 0, "R10 arm");
                cyc(0, 1, p, x0, "R7 R3 R2 first sample");
                for (int k = 0; k < idle; k++)
                    cyc(0, 0, ~p, 0, "R6 R8 idle");
                cyc(0, 1, c, x1, "R5 R4 R3 R9 second sample");
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule